// File: doc/BRIEF.md
# Warp Active-Lane Mask Tracker

This block follows which lanes of one warp are enabled while the warp runs through branches. A synchronous reset starts the warp. It loads the start address and builds the first lane mask from a thread count, so a last warp that is only partly filled begins with its unused lanes switched off. Each issued instruction moves the issue address forward. A branch carries a per-lane predicate vector. The block uses that vector to decide whether the enabled lanes agree. If they agree, the warp moves to the target or falls through with its mask unchanged and no extra cycle.

If the enabled lanes disagree, the block saves a reconvergence entry on a small stack and runs the taken lanes first. When that path reaches the reconvergence address, the other lanes run from the fall-through address. When the address is reached a second time, the mask held before the branch comes back and the entry is removed. Nested branches stack up in the same way, and each level can only narrow the mask. If a branch needs a new entry while the stack is full, the branch is refused and a sticky flag is raised.

Code running on the block must meet two conditions. The taken target and the fall-through address of a divergent branch both lie before its reconvergence address. Nested divergent branches reconverge at distinct addresses.

Top module: `warp_mask_stack`

## Requirements
- R1: While `rst` is high at a clock edge, the next state has `issue_pc` equal to `launch_pc`, `stack_ovf` low and the stack empty. Stack entries saved before the reset have no later effect.
- R2: After reset, bit i of `active_mask` is 1 exactly when i < `launch_cnt`. A count of `LANES` or more enables every lane, and a count of 0 enables none.
- R3: An issued non-branch instruction (`issue_vld`=1, `is_branch`=0) gives `issue_pc`+1 on the next cycle and leaves `active_mask` unchanged.
- R4: An issued branch whose enabled lanes all have predicate 1 moves `issue_pc` to `br_target`. One whose enabled lanes all have predicate 0 moves it to `issue_pc`+1. In both cases `active_mask` stays the same and no stack entry is made, so passing `br_reconv` later changes nothing.
- R5: Predicate bits of lanes that are 0 in `active_mask` have no effect on the result of a branch.
- R6: A divergent branch (some enabled lanes with predicate 1, some with 0) gives `issue_pc`=`br_target` and `active_mask`=`br_pred & active_mask` on the next cycle.
- R7: When the taken path of a divergent branch issues the instruction just before its reconvergence address, the next cycle gives `issue_pc` = branch address + 1 and a mask holding the enabled lanes that had predicate 0.
- R8: When the fall-through path then reaches the reconvergence address, the next cycle gives `issue_pc` equal to that address and the mask that was in force before the branch. The entry is removed.
- R9: A divergent branch inside a divergent region narrows the mask again. Its reconvergence restores the enclosing path's mask, and the outer reconvergence later restores the full mask from before the outer branch.
- R10: A divergent branch issued while `DEPTH` entries are in use leaves `issue_pc` and `active_mask` unchanged and sets `stack_ovf`. The flag stays set until reset.
- R11: While `issue_vld` is 0, `issue_pc` and `active_mask` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset; starts the warp |
| launch_pc | input | PC_W | Start address, sampled during reset |
| launch_cnt | input | $clog2(LANES+1) | Thread count of this warp, sampled during reset |
| issue_vld | input | 1 | The instruction at `issue_pc` is issued this cycle |
| is_branch | input | 1 | The issued instruction is a conditional branch |
| br_pred | input | LANES | Per-lane branch condition, 1 = taken |
| br_target | input | PC_W | Branch target address |
| br_reconv | input | PC_W | Address where the two paths meet again |
| issue_pc | output | PC_W | Address of the next instruction to issue |
| active_mask | output | LANES | Lanes enabled for that instruction |
| stack_ovf | output | 1 | Sticky flag: a divergent branch found the stack full |

## Verification
The bench builds the block with 32 lanes, a 12-bit address and a stack depth of only 2. With that depth, a third nested divergent branch reaches the full-stack refusal within a few instructions. Two levels of nesting still exercise the inner pop that hands control back to the outer pending path. The full 32-lane width lets thread counts of 0, 5, 31 and more than 32 test every mask edge, and lets predicates that set only disabled lanes check that those lanes are ignored.

// File: rtl/wms_pkg.sv
package wms_pkg;
    // outcome of evaluating one issued instruction
    typedef enum logic [1:0] {
        BK_SEQ   = 2'd0,  // not a branch
        BK_FALL  = 2'd1,  // all enabled lanes fall through
        BK_TAKE  = 2'd2,  // all enabled lanes take the branch
        BK_SPLIT = 2'd3   // enabled lanes disagree
    } br_kind_e;
endpackage

// File: rtl/wms_launch_mask.sv
module wms_launch_mask #(
    parameter int LANES = 32,
    parameter int CNT_W = $clog2(LANES + 1)
) (
    input  logic [CNT_W-1:0] cnt,
    output logic [LANES-1:0] mask
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign mask[g] = (cnt > CNT_W'(g));
    end
endmodule

// File: rtl/wms_branch_eval.sv
module wms_branch_eval #(
    parameter int LANES = 32
) (
    input  logic                 is_branch,
    input  logic [LANES-1:0]     active,
    input  logic [LANES-1:0]     pred,
    output logic [LANES-1:0]     taken_mask,
    output logic [LANES-1:0]     fall_mask,
    output wms_pkg::br_kind_e    kind
);
    // only enabled lanes contribute
    assign taken_mask = pred & active;
    assign fall_mask  = active & ~pred;

    always_comb begin
        if (!is_branch)
            kind = wms_pkg::BK_SEQ;
        else if (taken_mask == '0)
            kind = wms_pkg::BK_FALL;
        else if (taken_mask == active)
            kind = wms_pkg::BK_TAKE;
        else
            kind = wms_pkg::BK_SPLIT;
    end
endmodule

// File: rtl/wms_recon_stack.sv
module wms_recon_stack #(
    parameter int LANES = 32,
    parameter int PC_W  = 16,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [PC_W-1:0]  push_reconv,
    input  logic [PC_W-1:0]  push_pend_pc,
    input  logic [LANES-1:0] push_pend_mask,
    input  logic [LANES-1:0] push_rest_mask,
    input  logic             pop,
    input  logic             take_pend,
    output logic [PC_W-1:0]  top_reconv,
    output logic [PC_W-1:0]  top_pend_pc,
    output logic [LANES-1:0] top_pend_mask,
    output logic [LANES-1:0] top_rest_mask,
    output logic             top_pend_vld,
    output logic             empty,
    output logic             full
);
    localparam int SP_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PC_W-1:0]  reconv;
        logic [PC_W-1:0]  pend_pc;
        logic [LANES-1:0] pend_mask;
        logic [LANES-1:0] rest_mask;
        logic             pend_vld;
    } ent_t;

    ent_t            ent_q [DEPTH];
    ent_t            ent_d [DEPTH];
    logic [SP_W-1:0] sp_q, sp_d;
    logic [SP_W-1:0] top_idx;
    ent_t            top_ent;
    ent_t            new_ent;

    assign empty   = (sp_q == '0);
    assign full    = (sp_q == SP_W'(DEPTH));
    assign top_idx = sp_q - 1'b1;

    always_comb begin
        new_ent.reconv    = push_reconv;
        new_ent.pend_pc   = push_pend_pc;
        new_ent.pend_mask = push_pend_mask;
        new_ent.rest_mask = push_rest_mask;
        new_ent.pend_vld  = 1'b1;
    end

    always_comb begin
        top_ent = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!empty && SP_W'(i) == top_idx) top_ent = ent_q[i];
        end
    end

    assign top_reconv    = top_ent.reconv;
    assign top_pend_pc   = top_ent.pend_pc;
    assign top_pend_mask = top_ent.pend_mask;
    assign top_rest_mask = top_ent.rest_mask;
    assign top_pend_vld  = top_ent.pend_vld;

    always_comb begin
        sp_d = sp_q;
        for (int i = 0; i < DEPTH; i++) ent_d[i] = ent_q[i];
        if (push && !full) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (SP_W'(i) == sp_q) ent_d[i] = new_ent;
            end
            sp_d = sp_q + 1'b1;
        end else if (pop && !empty) begin
            sp_d = top_idx;
        end else if (take_pend && !empty) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (SP_W'(i) == top_idx) ent_d[i].pend_vld = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q <= '0;
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else begin
            sp_q <= sp_d;
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_d[i];
        end
    end
endmodule

// File: rtl/warp_mask_stack.sv
module warp_mask_stack #(
    parameter int LANES = 32,
    parameter int PC_W  = 16,
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(LANES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PC_W-1:0]  launch_pc,
    input  logic [CNT_W-1:0] launch_cnt,
    input  logic             issue_vld,
    input  logic             is_branch,
    input  logic [LANES-1:0] br_pred,
    input  logic [PC_W-1:0]  br_target,
    input  logic [PC_W-1:0]  br_reconv,
    output logic [PC_W-1:0]  issue_pc,
    output logic [LANES-1:0] active_mask,
    output logic             stack_ovf
);
    import wms_pkg::*;

    typedef struct packed {
        logic [PC_W-1:0]  pc;
        logic [LANES-1:0] mask;
        logic             ovf;
    } st_t;

    st_t st_q, st_d;

    logic [LANES-1:0] launch_mask;
    logic [LANES-1:0] taken_mask, fall_mask;
    br_kind_e         kind;

    logic             push, pop, take_pend;
    logic [PC_W-1:0]  top_reconv, top_pend_pc;
    logic [LANES-1:0] top_pend_mask, top_rest_mask;
    logic             top_pend_vld, stk_empty, stk_full;

    logic [PC_W-1:0]  seq_pc, cand_pc;
    logic [LANES-1:0] cand_mask;
    logic             chk_rc;

    wms_launch_mask #(.LANES(LANES), .CNT_W(CNT_W)) u_launch (
        .cnt  (launch_cnt),
        .mask (launch_mask)
    );

    wms_branch_eval #(.LANES(LANES)) u_eval (
        .is_branch  (is_branch),
        .active     (st_q.mask),
        .pred       (br_pred),
        .taken_mask (taken_mask),
        .fall_mask  (fall_mask),
        .kind       (kind)
    );

    wms_recon_stack #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) u_stack (
        .clk            (clk),
        .rst            (rst),
        .push           (push),
        .push_reconv    (br_reconv),
        .push_pend_pc   (seq_pc),
        .push_pend_mask (fall_mask),
        .push_rest_mask (st_q.mask),
        .pop            (pop),
        .take_pend      (take_pend),
        .top_reconv     (top_reconv),
        .top_pend_pc    (top_pend_pc),
        .top_pend_mask  (top_pend_mask),
        .top_rest_mask  (top_rest_mask),
        .top_pend_vld   (top_pend_vld),
        .empty          (stk_empty),
        .full           (stk_full)
    );

    assign seq_pc = st_q.pc + 1'b1;

    always_comb begin
        st_d      = st_q;
        push      = 1'b0;
        pop       = 1'b0;
        take_pend = 1'b0;
        cand_pc   = st_q.pc;
        cand_mask = st_q.mask;
        chk_rc    = 1'b0;
        if (issue_vld) begin
            cand_pc = seq_pc;
            chk_rc  = 1'b1;
            case (kind)
                BK_TAKE: cand_pc = br_target;
                BK_SPLIT: begin
                    chk_rc = 1'b0;
                    if (stk_full) begin
                        // refused branch: warp stays where it is
                        st_d.ovf = 1'b1;
                        cand_pc  = st_q.pc;
                    end else begin
                        push      = 1'b1;
                        cand_pc   = br_target;
                        cand_mask = taken_mask;
                    end
                end
                default: ;
            endcase
            if (chk_rc && !stk_empty && cand_pc == top_reconv) begin
                if (top_pend_vld) begin
                    take_pend = 1'b1;
                    cand_pc   = top_pend_pc;
                    cand_mask = top_pend_mask;
                end else begin
                    pop       = 1'b1;
                    cand_mask = top_rest_mask;
                end
            end
            st_d.pc   = cand_pc;
            st_d.mask = cand_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.pc   <= launch_pc;
            st_q.mask <= launch_mask;
            st_q.ovf  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign issue_pc    = st_q.pc;
    assign active_mask = st_q.mask;
    assign stack_ovf   = st_q.ovf;
endmodule

// File: rtl/wms_checker.sv
module wms_checker #(
    parameter int LANES = 32,
    parameter int PC_W  = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             issue_vld,
    input logic             is_branch,
    input logic [LANES-1:0] br_pred,
    input logic [PC_W-1:0]  br_target,
    input logic [PC_W-1:0]  issue_pc,
    input logic [LANES-1:0] active_mask,
    input logic             stack_ovf,
    input logic             stk_empty,
    input logic             stk_full
);
    AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        issue_vld && !is_branch && stk_empty
        |=> issue_pc == PC_W'($past(issue_pc) + 1'b1) && $stable(active_mask)); // R3

    AST_UNIFORM_FALL: assert property (@(posedge clk) disable iff (rst)
        issue_vld && is_branch && (br_pred & active_mask) == '0 && stk_empty
        |=> issue_pc == PC_W'($past(issue_pc) + 1'b1) && $stable(active_mask)); // R4

    AST_UNIFORM_TAKE: assert property (@(posedge clk) disable iff (rst)
        issue_vld && is_branch && active_mask != '0 &&
        (br_pred & active_mask) == active_mask && stk_empty
        |=> issue_pc == $past(br_target) && $stable(active_mask)); // R4

    AST_SPLIT_ENTRY: assert property (@(posedge clk) disable iff (rst)
        issue_vld && is_branch && !stk_full && (br_pred & active_mask) != '0 &&
        (br_pred & active_mask) != active_mask
        |=> issue_pc == $past(br_target) &&
            active_mask == $past(br_pred & active_mask)); // R6

    AST_OVF_REFUSE: assert property (@(posedge clk) disable iff (rst)
        issue_vld && is_branch && stk_full && (br_pred & active_mask) != '0 &&
        (br_pred & active_mask) != active_mask
        |=> stack_ovf && $stable(issue_pc) && $stable(active_mask)); // R10

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        stack_ovf |=> stack_ovf); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !issue_vld |=> $stable(issue_pc) && $stable(active_mask)); // R11
endmodule

bind warp_mask_stack wms_checker #(.LANES(LANES), .PC_W(PC_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .issue_vld   (issue_vld),
    .is_branch   (is_branch),
    .br_pred     (br_pred),
    .br_target   (br_target),
    .issue_pc    (issue_pc),
    .active_mask (active_mask),
    .stack_ovf   (stack_ovf),
    .stk_empty   (stk_empty),
    .stk_full    (stk_full)
);

// File: tb/sim_warp_mask_stack.sv
`timescale 1ns/1ps
module sim_warp_mask_stack;
    localparam int LANES = 32;
    localparam int PC_W  = 12;
    localparam int DEPTH = 2;
    localparam int CNT_W = $clog2(LANES + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [PC_W-1:0]  launch_pc = '0;
    logic [CNT_W-1:0] launch_cnt = '0;
    logic             issue_vld = 1'b0;
    logic             is_branch = 1'b0;
    logic [LANES-1:0] br_pred = '0;
    logic [PC_W-1:0]  br_target = '0;
    logic [PC_W-1:0]  br_reconv = '0;
    logic [PC_W-1:0]  issue_pc;
    logic [LANES-1:0] active_mask;
    logic             stack_ovf;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    warp_mask_stack #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .launch_pc(launch_pc), .launch_cnt(launch_cnt),
        .issue_vld(issue_vld), .is_branch(is_branch), .br_pred(br_pred),
        .br_target(br_target), .br_reconv(br_reconv), .issue_pc(issue_pc),
        .active_mask(active_mask), .stack_ovf(stack_ovf)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_state(input string tag, input logic [31:0] pc, input logic [31:0] m);
        check({tag, " pc"}, 32'(issue_pc), pc);
        check({tag, " mask"}, 32'(active_mask), m);
    endtask

    // one clock edge with the given inputs, sampled at the following falling edge
    task automatic cyc(input logic v, input logic br, input logic [31:0] p,
                       input int tgt, input int rc);
        issue_vld = v; is_branch = br; br_pred = p;
        br_target = PC_W'(tgt); br_reconv = PC_W'(rc);
        @(posedge clk);
        @(negedge clk);
        issue_vld = 1'b0; is_branch = 1'b0; br_pred = '0;
    endtask

    task automatic do_reset(input int pc, input int cnt);
        rst = 1'b1; launch_pc = PC_W'(pc); launch_cnt = CNT_W'(cnt);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, '0, 0, 0);
    endtask

    task automatic t_launch();
        do_reset(32'h100, 32);
        check_state("R1 reset full", 32'h100, 32'hFFFF_FFFF);
        check("R1 ovf clear", 32'(stack_ovf), 0);
        do_reset(0, 5);
        check_state("R2 count 5", 0, 32'h0000_001F);
        do_reset(0, 31);
        check("R2 count 31", 32'(active_mask), 32'h7FFF_FFFF);
        do_reset(0, 0);
        check("R2 count 0", 32'(active_mask), 0);
        do_reset(0, 40);
        check("R2 count 40", 32'(active_mask), 32'hFFFF_FFFF);
    endtask

    task automatic t_uniform();
        do_reset(0, 5);
        run(1);
        check_state("R3 sequential", 1, 32'h1F);
        // only disabled lanes set: uniform fall-through
        cyc(1'b1, 1'b1, 32'hFFFF_FFE0, 32'h30, 32'h31);
        check_state("R5 inactive pred fall", 2, 32'h1F);
        // enabled lanes all taken, garbage in disabled lanes
        cyc(1'b1, 1'b1, 32'h0000_0F1F, 32'h30, 32'h31);
        check_state("R4 uniform taken", 32'h30, 32'h1F);
        run(1);
        check_state("R4 no entry at reconv", 32'h31, 32'h1F);
        cyc(1'b0, 1'b1, 32'h0000_0003, 32'h50, 32'h51);
        cyc(1'b0, 1'b0, '0, 0, 0);
        check_state("R11 idle hold", 32'h31, 32'h1F);
    endtask

    task automatic t_split();
        do_reset(32'h10, 32);
        cyc(1'b1, 1'b1, 32'h0000_FFFF, 32'h14, 32'h18);
        check_state("R6 taken path", 32'h14, 32'h0000_FFFF);
        run(3);
        check_state("R6 taken path runs", 32'h17, 32'h0000_FFFF);
        run(1);
        check_state("R7 switch to fall path", 32'h11, 32'hFFFF_0000);
        run(7);
        check_state("R8 reconverge", 32'h18, 32'hFFFF_FFFF);
        run(1);
        check_state("R8 entry removed", 32'h19, 32'hFFFF_FFFF);
    endtask

    task automatic t_nested();
        do_reset(32'h20, 32);
        cyc(1'b1, 1'b1, 32'h0000_FFFF, 32'h30, 32'h40);
        check_state("R9 outer split", 32'h30, 32'h0000_FFFF);
        cyc(1'b1, 1'b1, 32'hFFFF_00FF, 32'h34, 32'h38);
        check_state("R9 inner split", 32'h34, 32'h0000_00FF);
        run(4);
        check_state("R9 inner fall path", 32'h31, 32'h0000_FF00);
        run(7);
        check_state("R9 inner reconverge", 32'h38, 32'h0000_FFFF);
        run(8);
        check_state("R9 outer fall path", 32'h21, 32'hFFFF_0000);
        run(31);
        check_state("R9 outer reconverge", 32'h40, 32'hFFFF_FFFF);
    endtask

    task automatic t_overflow();
        do_reset(32'h80, 32);
        cyc(1'b1, 1'b1, 32'h0000_FFFF, 32'h90, 32'hF0);
        cyc(1'b1, 1'b1, 32'h0000_00FF, 32'hA0, 32'hE0);
        check("R10 no ovf yet", 32'(stack_ovf), 0);
        cyc(1'b1, 1'b1, 32'h0000_000F, 32'hB0, 32'hD0);
        check_state("R10 refused branch", 32'hA0, 32'h0000_00FF);
        check("R10 ovf set", 32'(stack_ovf), 1);
        run(1);
        check("R10 ovf sticky", 32'(stack_ovf), 1);
        // reset while two entries are held; the old 0xE0 entry must be gone
        do_reset(32'hDF, 32);
        check("R1 ovf cleared", 32'(stack_ovf), 0);
        run(1);
        check_state("R1 stack cleared", 32'hE0, 32'hFFFF_FFFF);
    endtask

    initial begin
        #(5ns * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_launch();
        t_uniform();
        t_split();
        t_nested();
        t_overflow();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule